// File: doc/BRIEF.md
# I2C Bus Master with Four-Byte Transfer Buffers

This block drives an I2C bus as a master. It moves one to four data bytes per transfer between the bus and a pair of fixed four-byte buffers: a transmit buffer that the host fills before the transfer, and a receive buffer that the block fills during a read. The host presents the target address, the address width (7 or 10 bits), the direction, the byte count and the speed mode, then pulses a start request. The block then runs the whole bus sequence by itself: START, address bytes, data bytes with their acknowledge slots, and STOP.

Both bus lines are open-drain. The block only ever pulls a line low or releases it, and it reads back the resolved data line. This lets it share the bus with other masters. When it releases the data line to send a 1 but reads a 0, it has lost arbitration and gets off the bus at once.

A single interrupt request goes high when a transfer ends, whether it succeeded, was refused with a NACK, or lost arbitration. The request and the status flags stay high until the next accepted start. An abort input is the error-recovery action: it returns the controller to idle from any state.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, busy, irq, NACK status and arbitration status are 0, and neither bus line is pulled low. Whenever busy is 0, neither line is pulled low.
- R2: With 7-bit addressing, the first byte after START is {addr[6:0], rw}, where rw is 1 for a read and 0 for a write. Every byte is sent MSB first.
- R3: With 10-bit addressing, the first byte is {5'b11110, addr[9:8], rw} and the second byte is addr[7:0]. An ACK is checked after each of these bytes.
- R4: A write sends count_i+1 data bytes. Data byte k is taken from tx_buf_i[8k+7:8k], in order k = 0, 1, and so on.
- R5: A read receives count_i+1 data bytes. Byte k is stored in rx_buf_o[8k+7:8k]. The master ACKs (drives low) every received byte except the last one, which it NACKs (releases).
- R6: Every transfer that does not lose arbitration has exactly one START and ends with exactly one STOP. After it ends, both lines are released.
- R7: The SCL period is 4*QTR_STD clock cycles when fast_i=0 and 4*QTR_FAST clock cycles when fast_i=1.
- R8: A NACK on an address byte or a written data byte ends the transfer with a STOP and sets nack_o. No further bits are clocked, so the bus carries 9 SCL pulses per byte up to and including the refused byte, plus the STOP.
- R9: If the block releases SDA to send a 1 and samples 0 while SCL is high, it sets arb_lost_o and releases both lines on the next clock. It generates no STOP.
- R10: irq_o rises when a transfer ends and stays high, together with the status flags, until the next accepted start or an abort.
- R11: abort_i returns the block to idle on the next clock. This releases the lines and clears irq_o and the status flags. Abort takes priority over a start request in the same cycle.
- R12: A start request while busy is ignored, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| abort_i | input | 1 | Error-recovery: return to idle |
| addr_i | input | 10 | Target address |
| addr10_i | input | 1 | 1 = 10-bit address format |
| read_i | input | 1 | 1 = read, 0 = write |
| fast_i | input | 1 | 1 = 400 kHz timing, 0 = 100 kHz timing |
| count_i | input | 2 | Number of data bytes minus one |
| tx_buf_i | input | 32 | Transmit buffer, byte k at bits 8k+7:8k |
| sda_i | input | 1 | Resolved SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_buf_o | output | 32 | Receive buffer, byte k at bits 8k+7:8k |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Interrupt request, held until next start or abort |
| nack_o | output | 1 | Transfer was refused with a NACK |
| arb_lost_o | output | 1 | Arbitration was lost |

## Verification
Several pairs of events can land in the same clock cycle, and the bench provokes each one deliberately.

Abort and start: the bench raises both in one cycle while the block is idle and still holding irq from the previous transfer. It expects busy to stay low, irq to clear and no START to appear on the bus.

Start while busy: a second start is pulsed in the middle of a transfer with a different address. The bench then judges the whole transfer by the bytes a bus-level slave model recorded.

Competing master: a model pulls SDA low during the first address bit, so the arbitration sample and the release of both lines coincide. The bench expects the lines freed, no STOP, and irq raised.

Done and irq: the end of STOP and the rise of irq fall in the same cycle.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_XFER, PH_STOP} phase_t;

  // Address byte for header slot 0 or 1 of a transfer
  function automatic logic [7:0] hdr_byte(input logic [9:0] a, input logic ten,
                                          input logic rw, input logic second);
    if (!ten)        return {a[6:0], rw};
    else if (!second) return {5'b11110, a[9:8], rw};
    else             return a[7:0];
  endfunction

endpackage

// File: rtl/i2cm_qtr_tick.sv
`timescale 1ns/1ps
module i2cm_qtr_tick #(
  parameter int QTR_STD  = 250,
  parameter int QTR_FAST = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int QMAX = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
  localparam int CW   = $clog2(QMAX + 1);

  function automatic logic [CW-1:0] qtr_last(input logic f);
    return f ? CW'(QTR_FAST - 1) : CW'(QTR_STD - 1);
  endfunction

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == qtr_last(fast));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int BUF_BYTES = 4,
  localparam int CW = $clog2(BUF_BYTES),
  localparam int IW = $clog2(BUF_BYTES + 2),
  localparam int BW = 8 * BUF_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [9:0]    addr,
  input  logic          ten,
  input  logic          rd,
  input  logic [CW-1:0] cnt_m1,
  input  logic [BW-1:0] tx_buf,
  input  logic          tick,
  input  logic          sda_in,
  output logic          busy,
  output logic          scl_drv,
  output logic          sda_drv,
  output logic [BW-1:0] rx_buf,
  output logic          irq,
  output logic          nack_err,
  output logic          arb_lost,
  output logic          ev_arb,
  output logic          ev_nack,
  output logic          in_xfer,
  output logic          ack_slot
);
  phase_t        ph;
  logic [1:0]    q;
  logic [3:0]    bit_i;
  logic [IW-1:0] bidx, last_r;
  logic [CW-1:0] dcnt;
  logic [9:0]    a_r;
  logic          ten_r, rd_r;
  logic [BW-1:0] txb_r;
  logic [7:0]    shreg;

  logic       is_hdr, is_rdata, last, tx_bit, ev_sample;
  logic [7:0] cur_byte;

  assign is_hdr   = (bidx == '0) || (ten_r && bidx == IW'(1));
  assign is_rdata = rd_r && !is_hdr;
  assign last     = (bidx == last_r);
  assign cur_byte = is_hdr ? hdr_byte(a_r, ten_r, rd_r, bidx == IW'(1))
                           : txb_r[{dcnt, 3'b000} +: 8];
  assign tx_bit   = cur_byte[3'd7 - bit_i[2:0]];

  assign busy      = (ph != PH_IDLE);
  assign in_xfer   = (ph == PH_XFER);
  assign ack_slot  = in_xfer && (bit_i == 4'd8);
  assign ev_sample = tick && in_xfer && (q == 2'd1);
  assign ev_nack   = ev_sample && ack_slot && !is_rdata && sda_in;
  assign ev_arb    = ev_sample && !ack_slot && !is_rdata && tx_bit && !sda_in;

  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    case (ph)
      PH_START: begin
        sda_drv = q[1];
        scl_drv = (q == 2'd3);
      end
      PH_XFER: begin
        scl_drv = (q == 2'd0) || (q == 2'd3);
        if (ack_slot) sda_drv = is_rdata && !last;
        else          sda_drv = !is_rdata && !tx_bit;
      end
      PH_STOP: begin
        scl_drv = (q == 2'd0);
        sda_drv = (q < 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; q <= '0; bit_i <= '0; bidx <= '0; last_r <= '0; dcnt <= '0;
      a_r <= '0; ten_r <= 1'b0; rd_r <= 1'b0; txb_r <= '0; shreg <= '0;
      rx_buf <= '0; irq <= 1'b0; nack_err <= 1'b0; arb_lost <= 1'b0;
    end else if (abort) begin
      ph <= PH_IDLE; irq <= 1'b0; nack_err <= 1'b0; arb_lost <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph <= PH_START; q <= '0; bit_i <= '0; bidx <= '0; dcnt <= '0;
          a_r <= addr; ten_r <= ten; rd_r <= rd; txb_r <= tx_buf;
          last_r <= IW'(cnt_m1) + (ten ? IW'(2) : IW'(1));
          irq <= 1'b0; nack_err <= 1'b0; arb_lost <= 1'b0;
        end
        PH_START: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) ph <= PH_XFER;
        end
        PH_XFER: if (tick) begin
          q <= q + 2'd1;
          if (ev_arb) begin
            ph <= PH_IDLE; arb_lost <= 1'b1; irq <= 1'b1;
          end else if (ev_nack) begin
            nack_err <= 1'b1;
          end else if (ev_sample && is_rdata) begin
            if (ack_slot) rx_buf[{dcnt, 3'b000} +: 8] <= shreg;
            else          shreg <= {shreg[6:0], sda_in};
          end
          if (q == 2'd3) begin
            if (ack_slot) begin
              if (nack_err || last) ph <= PH_STOP;
              else begin
                bidx  <= bidx + IW'(1);
                bit_i <= '0;
                if (!is_hdr) dcnt <= dcnt + CW'(1);
              end
            end else begin
              bit_i <= bit_i + 4'd1;
            end
          end
        end
        PH_STOP: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            ph <= PH_IDLE; irq <= 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int BUF_BYTES = 4,
  parameter int QTR_STD   = 250,
  parameter int QTR_FAST  = 63,
  localparam int CW = $clog2(BUF_BYTES),
  localparam int BW = 8 * BUF_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [9:0]    addr_i,
  input  logic          addr10_i,
  input  logic          read_i,
  input  logic          fast_i,
  input  logic [CW-1:0] count_i,
  input  logic [BW-1:0] tx_buf_i,
  input  logic          sda_i,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic [BW-1:0] rx_buf_o,
  output logic          busy_o,
  output logic          irq_o,
  output logic          nack_o,
  output logic          arb_lost_o
);
  logic tick, ev_arb, ev_nack, in_xfer, ack_slot;

  i2cm_qtr_tick #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy_o), .fast(fast_i), .tick(tick)
  );

  i2cm_engine #(.BUF_BYTES(BUF_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_i), .abort(abort_i),
    .addr(addr_i), .ten(addr10_i), .rd(read_i), .cnt_m1(count_i),
    .tx_buf(tx_buf_i), .tick(tick), .sda_in(sda_i),
    .busy(busy_o), .scl_drv(scl_low_o), .sda_drv(sda_low_o),
    .rx_buf(rx_buf_o), .irq(irq_o), .nack_err(nack_o), .arb_lost(arb_lost_o),
    .ev_arb(ev_arb), .ev_nack(ev_nack), .in_xfer(in_xfer), .ack_slot(ack_slot)
  );
endmodule

// File: rtl/i2cm_checker.sv
`timescale 1ns/1ps
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic abort,
  input logic busy,
  input logic scl_low,
  input logic sda_low,
  input logic irq,
  input logic nack,
  input logic arb,
  input logic ev_arb,
  input logic ev_nack,
  input logic in_xfer,
  input logic ack_slot
);
  // R1: idle block never holds a line low
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  // R11: abort clears everything on the next clock
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !irq && !nack && !arb));

  // R9: lost arbitration frees the bus next clock
  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb && !abort) |=> (arb && !busy && !scl_low && !sda_low && irq));

  // R8: after a NACK no new bit slot is entered
  a_r8_nack_stops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && in_xfer) |-> ack_slot);

  // R8: a refused byte leads to the NACK flag
  a_r8_nack_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack && !abort) |=> nack);

  // R10: irq holds until start or abort
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !start && !abort) |=> irq);

  // R12: a transfer only begins from a start request
  a_r12_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .abort(abort_i), .busy(busy_o),
  .scl_low(scl_low_o), .sda_low(sda_low_o), .irq(irq_o), .nack(nack_o),
  .arb(arb_lost_o), .ev_arb(ev_arb), .ev_nack(ev_nack), .in_xfer(in_xfer),
  .ack_slot(ack_slot)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q_STD  = 6;
  localparam int Q_FAST = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, ten = 1'b0, rd = 1'b0, fast = 1'b0;
  logic [9:0]  addr = '0;
  logic [1:0]  cnt = '0;
  logic [31:0] txb = '0;
  logic scl_low, sda_low, busy, irq, nack, arb;
  logic [31:0] rxb;
  logic slv_pull = 1'b0;

  wire scl_l = !scl_low;
  wire sda_l = !(sda_low || slv_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_master #(.BUF_BYTES(4), .QTR_STD(Q_STD), .QTR_FAST(Q_FAST)) u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .addr_i(addr),
    .addr10_i(ten), .read_i(rd), .fast_i(fast), .count_i(cnt), .tx_buf_i(txb),
    .sda_i(sda_l), .scl_low_o(scl_low), .sda_low_o(sda_low), .rx_buf_o(rxb),
    .busy_o(busy), .irq_o(irq), .nack_o(nack), .arb_lost_o(arb)
  );

  int errors = 0, checks = 0;
  bit done_flag = 0;
  int n_start = 0, n_stop = 0, n_rise = 0;
  time t_prev = 0, t_last = 0;

  always @(negedge sda_l) if (scl_l) n_start++;
  always @(posedge sda_l) if (scl_l) n_stop++;
  always @(posedge scl_l) begin n_rise++; t_prev = t_last; t_last = $time; end

  // bus-level slave model
  int s_total = 0, s_hdr = 1, s_nack_at = 99;
  bit s_rd = 0, s_arb = 0;
  logic [31:0] s_rdata = '0;
  logic [7:0] got [0:7];
  logic mack [0:3];

  task automatic slave_xfer();
    if (s_arb) begin
      @(negedge scl_l);
      slv_pull = 1'b1;
      return;
    end
    for (int b = 0; b < s_total; b++) begin
      if (s_rd && b >= s_hdr) begin
        logic [7:0] d;
        d = s_rdata[8*(b-s_hdr) +: 8];
        for (int i = 0; i < 8; i++) begin
          slv_pull = !d[7-i];
          @(posedge scl_l);
          @(negedge scl_l);
        end
        slv_pull = 1'b0;
        @(posedge scl_l);
        mack[b-s_hdr] = sda_l;
        @(negedge scl_l);
      end else begin
        logic [7:0] v;
        v = '0;
        for (int i = 0; i < 8; i++) begin
          @(posedge scl_l);
          v = {v[6:0], sda_l};
          @(negedge scl_l);
        end
        got[b] = v;
        slv_pull = (b != s_nack_at);
        @(posedge scl_l);
        @(negedge scl_l);
        slv_pull = 1'b0;
        if (b == s_nack_at) return;
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge sda_l);
      if (scl_l) slave_xfer();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // runs one transfer and checks it at the bus and at the ports
  task automatic run_xfer(input logic [9:0] a, input bit t10, input bit r, input logic [1:0] c,
                          input bit f, input logic [31:0] tx, input logic [31:0] rdat,
                          input int nack_at, input bit poke);
    int s0, p0, r0, hdr, total, sent, n;
    logic [7:0] eh0, eh1;
    hdr = t10 ? 2 : 1;
    total = hdr + int'(c) + 1;
    sent = (nack_at < total) ? nack_at + 1 : total;
    s_total = total; s_hdr = hdr; s_rd = r; s_nack_at = nack_at; s_arb = 0; s_rdata = rdat;
    @(negedge clk);
    addr = a; ten = t10; rd = r; cnt = c; fast = f; txb = tx;
    s0 = n_start; p0 = n_stop; r0 = n_rise;
    pulse_start();
    if (poke) begin
      repeat (40) @(negedge clk);
      addr = ~a; ten = !t10; start = 1'b1;
      @(negedge clk) start = 1'b0;
      addr = a; ten = t10;
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(!busy, "R6 transfer completes", {31'd0, busy}, 32'd0);
    repeat (2) @(negedge clk);
    chk(n_start - s0 == 1, "R6 one START", n_start - s0, 1);
    chk(n_stop - p0 == 1, "R6 one STOP", n_stop - p0, 1);
    chk(!scl_low && !sda_low, "R6 lines released", {scl_low, sda_low}, 0);
    chk(n_rise - r0 == 9*sent + 1, "R8 SCL pulse count", n_rise - r0, 9*sent + 1);
    chk((t_last - t_prev) == 4*(f ? Q_FAST : Q_STD)*CLK_PERIOD, "R7 SCL period",
        t_last - t_prev, 4*(f ? Q_FAST : Q_STD)*CLK_PERIOD);
    if (t10) begin
      eh0 = 8'hF0 + 8'(a[9:8]) * 2 + 8'(r);
      eh1 = a[7:0];
      chk(got[0] == eh0, "R3 first 10-bit byte", got[0], eh0);
      if (sent > 1) chk(got[1] == eh1, "R3 low address byte", got[1], eh1);
    end else begin
      eh0 = 8'(a[6:0]) * 2 + 8'(r);
      chk(got[0] == eh0, "R2 7-bit address byte", got[0], eh0);
    end
    if (r && nack_at >= total) begin
      for (int k = 0; k <= int'(c); k++) begin
        chk(rxb[8*k +: 8] == rdat[8*k +: 8], "R5 received byte", rxb[8*k +: 8], rdat[8*k +: 8]);
        chk(mack[k] == (k == int'(c)), "R5 master ack bit", mack[k], (k == int'(c)));
      end
    end else if (!r) begin
      for (int k = 0; k < sent - hdr; k++)
        chk(got[hdr+k] == tx[8*k +: 8], "R4 written byte", got[hdr+k], tx[8*k +: 8]);
    end
    chk(nack == (nack_at < total), "R8 nack flag", nack, (nack_at < total));
    chk(irq && !arb, "R10 irq at end", {irq, arb}, 2'b10);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!busy && !irq && !nack && !arb && !scl_low && !sda_low, "R1 reset state",
        {busy, irq, nack, arb, scl_low, sda_low}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep address width, direction, count and speed
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [9:0]  a;
      logic [31:0] tx, rdat;
      a    = 10'h2B5 ^ 10'(cfg * 37);
      tx   = 32'h3C5A96E1 ^ (32'(cfg) * 32'h07070707);
      rdat = 32'hD2194B7E ^ (32'(cfg) * 32'h0B0B0B0B);
      run_xfer(a, cfg[0], cfg[1], 2'(cfg >> 2), cfg[0] ^ cfg[2], tx, rdat, 99, cfg == 5);
    end

    // R8 refusals: on the address, on a data byte, on the 10-bit low byte of a read
    run_xfer(10'h03C, 0, 0, 2'd2, 0, 32'h11223344, 32'h0, 0, 0);
    run_xfer(10'h1A7, 1, 0, 2'd3, 1, 32'h55667788, 32'h0, 3, 0);
    run_xfer(10'h2E1, 1, 1, 2'd1, 0, 32'h0, 32'hCAFE0BAD, 1, 0);

    // R10 irq holds while idle
    repeat (20) @(negedge clk);
    chk(irq && nack, "R10 irq and status held", {irq, nack}, 2'b11);

    // R9 competing master wins the first address bit
    begin
      int p0, r0, n;
      s_arb = 1;
      @(negedge clk);
      addr = 10'h05A; ten = 0; rd = 0; cnt = 0; fast = 0;
      p0 = n_stop; r0 = n_rise;
      pulse_start();
      n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk(!busy && arb && irq, "R9 arbitration lost", {busy, arb, irq}, 3'b011);
      chk(!scl_low && !sda_low, "R9 lines released", {scl_low, sda_low}, 0);
      chk(n_stop == p0, "R9 no STOP", n_stop - p0, 0);
      chk(n_rise - r0 == 1, "R9 single SCL pulse", n_rise - r0, 1);
      slv_pull = 1'b0;
      s_arb = 0;
      repeat (5) @(negedge clk);
    end

    // R11 abort and start in one cycle: abort wins and clears irq
    begin
      int s0;
      s0 = n_start;
      @(negedge clk) begin start = 1'b1; abort = 1'b1; end
      @(negedge clk) begin start = 1'b0; abort = 1'b0; end
      chk(!busy && !irq && !arb, "R11 abort beats start", {busy, irq, arb}, 0);
      repeat (30) @(negedge clk);
      chk(n_start == s0 && !busy, "R11 no transfer begun", n_start - s0, 0);
    end

    // R11 abort in the middle of a transfer
    s_total = 5; s_hdr = 1; s_rd = 0; s_nack_at = 99;
    @(negedge clk);
    addr = 10'h066; ten = 0; rd = 0; cnt = 2'd3; fast = 0; txb = 32'hA1B2C3D4;
    pulse_start();
    repeat (150) @(negedge clk);
    chk(busy, "R11 busy before abort", busy, 1);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(!busy && !scl_low && !sda_low && !irq && !nack,
        "R11 abort returns to idle", {busy, scl_low, sda_low, irq, nack}, 0);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule